// File: doc/BRIEF.md
# Frequency Lock Detector

This block watches a clock-and-data-recovery loop and decides whether that loop is really following the incoming data. It counts edges of the recovered clock over a window of 2^WIN_LOG2 reference-clock cycles. It then compares that count with an expected count, plus or minus a programmable tolerance. A count inside that band means the two clocks agree closely enough.

When the loop is not locked, the block steers it onto the local reference. This keeps the recovered clock at the right frequency. After a hold time of a few windows, the block steers the loop back to the data and measures again. Lock is declared only after two clean windows in a row. One bad window is enough to drop it.

Two signal-detect inputs of opposite sense are combined by XOR. When they agree (XOR equals 0), the block forces the loop out of lock. A diagnostic-loopback enable makes the block ignore the signal-detect pair.

The edge count crosses from the recovered domain into the reference domain through a toggle request and a toggle acknowledge. Each toggle passes through two synchronising flops. The signal-detect and loopback inputs are taken as synchronous to the reference clock.

Top module: `freq_lock_detector`

## Requirements
- R1: While reset is active and right after it, lock_o is 0 and trk_ref_o is 1, so the loop is steered to the reference.
- R2: A window holds 2^WIN_LOG2 reference cycles. It passes when the recovered-edge count lies in EXP_CNT-TOL to EXP_CNT+TOL inclusive. With the defaults (64, tolerance 4), a recovered period of 7.8 to 8.25 ns passes and 7.2 or 9.0 ns fails, against an 8 ns reference.
- R3: A failing window that is used for the decision clears lock_o and sets trk_ref_o one reference cycle after the measurement.
- R4: After each out-of-lock decision, trk_ref_o stays 1 for HOLD_WIN completed measurement windows. It then falls to 0 to poll the data. With the defaults this is 120 to 208 reference cycles after signal detect returns.
- R5: The first window after trk_ref_o falls is discarded. Two consecutive passing windows after it set lock_o. With the defaults this comes 120 to 200 reference cycles after trk_ref_o falls.
- R6: The signal is good when sd_pos XOR sd_neg equals 1. While it is 0 and dlb_en is 0, lock_o is 0 and trk_ref_o is 1 from the next reference edge on.
- R7: While dlb_en is 1, the sd_pos and sd_neg inputs have no effect on lock_o or trk_ref_o.
- R8: While the recovered frequency stays out of tolerance, the block keeps repeating hold and poll. trk_ref_o falls again and again, and lock_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock, which also clocks the decision logic |
| rec_clk | input | 1 | Recovered clock from the recovery loop |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sd_pos | input | 1 | Signal detect, active-high sense |
| sd_neg | input | 1 | Signal detect, active-low sense |
| dlb_en | input | 1 | Diagnostic loopback; 1 ignores signal detect |
| lock_o | output | 1 | 1 when locked to data |
| trk_ref_o | output | 1 | 1 steers the loop to the reference, 0 to the data |

## Verification
A signal-detect change shows up one reference edge later. The bench checks it at the first falling edge after the rising edge that registers it. Frequency results only appear at window ends, after the request and acknowledge synchronisers. For those, the bench either lets sixteen windows settle before sampling a table row, or it counts reference cycles until an output edge and compares that count with a band. The band is one window wide, to allow for the phase of the window and the synchroniser delay.

// File: rtl/fld_pkg.sv
package fld_pkg;
  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_PROBE  = 3'd2,
    ST_ONEOK  = 3'd3,
    ST_LOCKED = 3'd4
  } fld_state_e;

  // Pass test for one window: count inside the band around the expected value.
  function automatic logic in_tol(input int cnt, input int exp_c, input int tol);
    return (cnt >= exp_c - tol) && (cnt <= exp_c + tol);
  endfunction
endpackage

// File: rtl/fld_rec_counter.sv
module fld_rec_counter #(
  parameter int CNT_W = 8
) (
  input  logic             rec_clk,
  input  logic             rst_n,
  input  logic             req_tgl,
  output logic [CNT_W-1:0] cnt_hold,
  output logic             ack_tgl
);
  logic [1:0]       req_sync;
  logic             req_seen;
  logic [CNT_W-1:0] cnt;
  logic             req_edge;

  assign req_edge = req_sync[1] ^ req_seen;

  always_ff @(posedge rec_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      req_seen <= 1'b0;
      cnt      <= '0;
      cnt_hold <= '0;
      ack_tgl  <= 1'b0;
    end else begin
      req_sync <= {req_sync[0], req_tgl};
      req_seen <= req_sync[1];
      if (req_edge) begin
        cnt_hold <= cnt;
        cnt      <= '0;
        ack_tgl  <= ~ack_tgl;
      end else if (cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: the captured count only moves on a window request
  a_r2_hold_stable: assert property (@(posedge rec_clk) disable iff (!rst_n)
    !req_edge |=> $stable(cnt_hold));
endmodule

// File: rtl/fld_ref_window.sv
module fld_ref_window #(
  parameter int WIN_LOG2 = 6,
  parameter int CNT_W    = 8
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             ack_tgl,
  input  logic [CNT_W-1:0] cnt_hold,
  output logic             req_tgl,
  output logic             meas_v,
  output logic [CNT_W-1:0] meas_cnt
);
  logic [WIN_LOG2-1:0] win;
  logic [1:0]          ack_sync;
  logic                ack_seen;
  logic                ack_edge;

  assign ack_edge = ack_sync[1] ^ ack_seen;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win      <= '0;
      req_tgl  <= 1'b0;
      ack_sync <= '0;
      ack_seen <= 1'b0;
      meas_v   <= 1'b0;
      meas_cnt <= '0;
    end else begin
      win      <= win + 1'b1;
      if (&win) req_tgl <= ~req_tgl;
      ack_sync <= {ack_sync[0], ack_tgl};
      ack_seen <= ack_sync[1];
      meas_v   <= ack_edge;
      if (ack_edge) meas_cnt <= cnt_hold;
    end
  end

  // R2: one measurement strobe per window
  a_r2_meas_pulse: assert property (@(posedge ref_clk) disable iff (!rst_n)
    meas_v |=> !meas_v);
endmodule

// File: rtl/fld_lock_fsm.sv
module fld_lock_fsm
  import fld_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int EXP_CNT  = 64,
  parameter int TOL      = 4,
  parameter int HOLD_WIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_v,
  input  logic [CNT_W-1:0] meas_cnt,
  input  logic             sig_ok,
  output logic             lock_o,
  output logic             trk_ref_o
);
  localparam int HC_W = $clog2(HOLD_WIN + 1);

  fld_state_e      state;
  logic [HC_W-1:0] hold_cnt;
  logic            meas_ok;
  logic            hold_done;
  logic            discard;

  assign meas_ok   = in_tol(int'(meas_cnt), EXP_CNT, TOL);
  assign hold_done = (hold_cnt == HC_W'(HOLD_WIN));
  assign discard   = (state == ST_SETTLE);
  assign lock_o    = (state == ST_LOCKED);
  assign trk_ref_o = (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HOLD;
      hold_cnt <= '0;
    end else if (!sig_ok) begin
      state    <= ST_HOLD;
      hold_cnt <= '0;
    end else begin
      if (state != ST_HOLD) hold_cnt <= '0;
      unique case (state)
        ST_HOLD: begin
          if (hold_done)   state    <= ST_SETTLE;
          else if (meas_v) hold_cnt <= hold_cnt + 1'b1;
        end
        ST_SETTLE: if (meas_v) state <= ST_PROBE;
        ST_PROBE:  if (meas_v) state <= meas_ok ? ST_ONEOK  : ST_HOLD;
        ST_ONEOK:  if (meas_v) state <= meas_ok ? ST_LOCKED : ST_HOLD;
        ST_LOCKED: if (meas_v && !meas_ok) state <= ST_HOLD;
        default:   state <= ST_HOLD;
      endcase
    end
  end

  a_r3_bad_window: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_v && !meas_ok && !discard && !trk_ref_o) |=> (trk_ref_o && !lock_o));
  a_r6_sig_lost: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_ok |=> (trk_ref_o && !lock_o));
  a_r5_lock_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(meas_v && meas_ok));
  a_r4_poll_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trk_ref_o) |-> $past(hold_done));
endmodule

// File: rtl/freq_lock_detector.sv
module freq_lock_detector #(
  parameter int WIN_LOG2 = 6,
  parameter int EXP_CNT  = 64,
  parameter int TOL      = 4,
  parameter int HOLD_WIN = 3
) (
  input  logic ref_clk,
  input  logic rec_clk,
  input  logic rst_n,
  input  logic sd_pos,
  input  logic sd_neg,
  input  logic dlb_en,
  output logic lock_o,
  output logic trk_ref_o
);
  localparam int CNT_W = WIN_LOG2 + 2;

  logic             req_tgl;
  logic             ack_tgl;
  logic [CNT_W-1:0] cnt_hold;
  logic             meas_v;
  logic [CNT_W-1:0] meas_cnt;
  logic             sig_ok;

  // R6/R7: loopback overrides the signal-detect pair
  assign sig_ok = dlb_en | (sd_pos ^ sd_neg);

  fld_rec_counter #(.CNT_W(CNT_W)) u_rec (
    .rec_clk(rec_clk), .rst_n(rst_n), .req_tgl(req_tgl),
    .cnt_hold(cnt_hold), .ack_tgl(ack_tgl));

  fld_ref_window #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_win (
    .ref_clk(ref_clk), .rst_n(rst_n), .ack_tgl(ack_tgl), .cnt_hold(cnt_hold),
    .req_tgl(req_tgl), .meas_v(meas_v), .meas_cnt(meas_cnt));

  fld_lock_fsm #(.CNT_W(CNT_W), .EXP_CNT(EXP_CNT), .TOL(TOL), .HOLD_WIN(HOLD_WIN)) u_fsm (
    .clk(ref_clk), .rst_n(rst_n), .meas_v(meas_v), .meas_cnt(meas_cnt),
    .sig_ok(sig_ok), .lock_o(lock_o), .trk_ref_o(trk_ref_o));

  a_r7_loopback_keeps_lock: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (dlb_en && lock_o && !meas_v) |=> lock_o);
endmodule

// File: tb/tb_freq_lock_detector.sv
`timescale 1ns/1ps
module tb_freq_lock_detector;
  localparam int WIN  = 64;
  localparam int HOLD = 3;

  typedef struct packed {
    logic [15:0] half_ps;
    logic        sdp;
    logic        sdn;
    logic        dlb;
    logic        exp_lock;
    logic [1:0]  exp_ref;   // 2 = either value allowed
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{16'd4000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0},  // R2 R5 nominal
    '{16'd3600, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2},  // R3 fast
    '{16'd4125, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0},  // R2 slightly slow
    '{16'd4500, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2},  // R3 slow
    '{16'd3900, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0},  // R2 slightly fast
    '{16'd4000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1},  // R6 both high
    '{16'd4000, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0},  // R7 loopback
    '{16'd4000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1},  // R6 both low
    '{16'd4000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0}   // R5 recover
  };

  logic ref_clk = 1'b0;
  logic rec_clk = 1'b0;
  logic rst_n = 1'b0;
  logic sd_pos = 1'b1, sd_neg = 1'b0, dlb_en = 1'b0;
  logic lock_o, trk_ref_o;
  realtime rec_half = 4.0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  freq_lock_detector dut (
    .ref_clk(ref_clk), .rec_clk(rec_clk), .rst_n(rst_n), .sd_pos(sd_pos),
    .sd_neg(sd_neg), .dlb_en(dlb_en), .lock_o(lock_o), .trk_ref_o(trk_ref_o));

  always #4 ref_clk = ~ref_clk;
  always begin #(rec_half) rec_clk = ~rec_clk; end

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int cyc;
    int falls;
    logic prev;
    logic saw_lock;
    // R1: reset state
    wait_cyc(3);
    chk("R1 lock in reset", int'(lock_o), 0);
    chk("R1 trk_ref in reset", int'(trk_ref_o), 1);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 lock after reset", int'(lock_o), 0);
    chk("R1 trk_ref after reset", int'(trk_ref_o), 1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      rec_half = real'(VEC[i].half_ps) / 1000.0;
      sd_pos = VEC[i].sdp; sd_neg = VEC[i].sdn; dlb_en = VEC[i].dlb;
      wait_cyc(16 * WIN);
      chk($sformatf("R2/R3/R5/R6/R7 vec%0d lock", i), int'(lock_o), int'(VEC[i].exp_lock));
      if (VEC[i].exp_ref != 2'd2)
        chk($sformatf("R2/R3/R5/R6/R7 vec%0d trk_ref", i), int'(trk_ref_o), int'(VEC[i].exp_ref));
    end

    // R6: one-edge response to signal loss, from lock
    chk("R6 precondition lock", int'(lock_o), 1);
    sd_pos = 1'b1; sd_neg = 1'b1;
    wait_cyc(1);
    chk("R6 lock next edge", int'(lock_o), 0);
    chk("R6 trk_ref next edge", int'(trk_ref_o), 1);
    wait_cyc(5 * WIN);
    chk("R6 trk_ref held", int'(trk_ref_o), 1);

    // R4: hold length after signal returns
    sd_neg = 1'b0;
    cyc = 0;
    while (trk_ref_o && cyc < 1000) begin wait_cyc(1); cyc++; end
    chk_rng("R4 hold cycles", cyc, 120, 208);

    // R5: discard then two passing windows
    cyc = 0;
    while (!lock_o && cyc < 1000) begin wait_cyc(1); cyc++; end
    chk_rng("R5 lock cycles after poll", cyc, 120, 200);

    // R7: loopback masks a signal-detect drop
    dlb_en = 1'b1; sd_pos = 1'b0; sd_neg = 1'b0;
    wait_cyc(1);
    chk("R7 lock next edge", int'(lock_o), 1);
    wait_cyc(10 * WIN);
    chk("R7 lock after windows", int'(lock_o), 1);
    chk("R7 trk_ref after windows", int'(trk_ref_o), 0);
    dlb_en = 1'b0; sd_pos = 1'b1;

    // R8: repeated polling under bad frequency
    rec_half = 3.6;
    wait_cyc(4 * WIN);
    falls = 0; saw_lock = 1'b0; prev = trk_ref_o;
    for (int k = 0; k < 40 * WIN; k++) begin
      wait_cyc(1);
      if (prev && !trk_ref_o) falls++;
      if (lock_o) saw_lock = 1'b1;
      prev = trk_ref_o;
    end
    chk_rng("R8 poll attempts", falls, 3, 40);
    chk("R8 no lock while off frequency", int'(saw_lock), 0);

    // R1: mid-run reset from lock
    rec_half = 4.0;
    wait_cyc(16 * WIN);
    chk("R1 precondition lock", int'(lock_o), 1);
    rst_n = 1'b0;
    wait_cyc(1);
    chk("R1 lock on reset", int'(lock_o), 0);
    chk("R1 trk_ref on reset", int'(trk_ref_o), 1);
    rst_n = 1'b1;
    wait_cyc(2);
    finish_run();
  end
endmodule